// File: doc/BRIEF.md
# Configurable Quadrature Event Counter

This block keeps a 16-bit up/down position count. It is driven by two encoder phase inputs (A and B), a trigger input, an external single-cycle event pulse, and the overflow and underflow pulses of a neighbouring counter unit. Each of the three pin inputs is first passed through a two-flop synchroniser. It can then also pass through a sampling glitch filter, which has its own clock divider.

Thirteen count conditions are decoded from the conditioned signals. Each condition has one enable bit in an increment mask and one in a decrement mask. One encoder scheme can therefore be chosen by software: single, double or quadruple resolution, in either direction. The count can be loaded directly. When it wraps, it raises its own overflow or underflow pulse, so that a second unit can be cascaded from it.

Top module: `quad_event_counter`

## Requirements
- R1: While reset is asserted and after its release, the count is 0 and the wrap outputs `ovf` and `unf` are 0.
- R2: When `load_en` is high at a clock edge, the count takes `load_val` at that edge. Load has priority over every count condition, and it raises neither `ovf` nor `unf`.
- R3: The eight encoder conditions use these mask bits:
  - bit0: B rises while A is low.
  - bit1: B falls while A is low.
  - bit2: B rises while A is high.
  - bit3: B falls while A is high.
  - bit4: A rises while B is low.
  - bit5: A falls while B is low.
  - bit6: A rises while B is high.
  - bit7: A falls while B is high.
  
  The qualifying level is the other input's conditioned level before the edge. With filtering off, a change on a pin appears in the count at the third rising clock edge after the change.
- R4: Mask bit8 selects a rising edge of the trigger input, and bit9 selects a falling edge.
- R5: Mask bit10 selects `evt_in`, bit11 selects `nbr_ovf` and bit12 selects `nbr_unf`. Each such input that is high at a clock edge gives one step at that edge.
- R6: In one cycle, if any enabled increment condition fires together with any enabled decrement condition, the count is unchanged. Several increment conditions that fire together, with no decrement, give exactly one step.
- R7: An increment from 0xFFFF gives 0 and pulses `ovf` high for one cycle. A decrement from 0 gives 0xFFFF and pulses `unf` for one cycle.
- R8: When the filter enable of an input is 0, the input passes through the synchroniser only, so a pulse two clocks wide is still counted.
- R9: When the filter enable of an input is 1, the conditioned level changes only after three consecutive equal samples taken at the filter clock rate. A two-clock pulse at filter select 0 is rejected.
- R10: A filter select of 0, 1, 2 or 3 takes one sample every 1, 4, 16 or 64 clocks. At select 1, a 6-clock pulse is rejected, while at select 0 the same pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A pin |
| enc_b | input | 1 | Encoder phase B pin |
| trig_in | input | 1 | Trigger pin |
| evt_in | input | 1 | Synchronous external event pulse |
| nbr_ovf | input | 1 | Overflow pulse of the paired unit |
| nbr_unf | input | 1 | Underflow pulse of the paired unit |
| flt_en | input | 3 | Filter enables: bit0 A, bit1 B, bit2 trigger |
| flt_sel_a | input | 2 | Filter clock select for A |
| flt_sel_b | input | 2 | Filter clock select for B |
| flt_sel_t | input | 2 | Filter clock select for trigger |
| inc_mask | input | 13 | Per-condition increment enables |
| dec_mask | input | 13 | Per-condition decrement enables |
| load_en | input | 1 | Load the count |
| load_val | input | 16 | Value to load |
| count | output | 16 | Current count |
| ovf | output | 1 | One-cycle pulse on an up-wrap |
| unf | output | 1 | One-cycle pulse on a down-wrap |

## Verification
The three latencies are as follows:
- A load and the synchronous pulse inputs take effect at the next rising edge. `ovf` and `unf` are registered alongside the count.
- A pin change with filtering off reaches the count at the third rising edge. The bench checks this exactly, at the second and the third falling edge after the change.
- A filtered pin needs three accepted samples, which can take up to about 3×64 clocks at select 3.

The table vectors and the filter tests therefore drive inputs on falling edges and wait a settle window longer than the worst filter latency before they compare the count. Pulse widths are chosen so that, whatever the divider phase, they cover either fewer than three sample ticks or clearly three or more.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int NUM_COND = 13;
  localparam int NUM_PIN  = 3;
  localparam int PIN_A = 0;
  localparam int PIN_B = 1;
  localparam int PIN_T = 2;
  localparam int PRE_W = 6;

  // sample-tick mask for filter clock select 0..3 -> 1,4,16,64
  function automatic logic [PRE_W-1:0] tick_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'h00;
      2'd1:    return 6'h03;
      2'd2:    return 6'h0F;
      default: return 6'h3F;
    endcase
  endfunction
endpackage

// File: rtl/qec_filter.sv
module qec_filter #(
  parameter int SAMPLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       flt_on,
  input  logic [1:0] sel,
  output logic       dout
);
  import qec_pkg::*;

  logic                 sy1, sy2;
  logic [SAMPLES-2:0]   hist;
  logic                 held;
  logic [PRE_W-1:0]     pre;
  logic                 tick;
  logic                 all_hi, all_lo;

  assign tick   = ((pre & tick_mask(sel)) == '0);
  assign all_hi = &{hist, sy2};
  assign all_lo = ~|{hist, sy2};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1  <= 1'b0;
      sy2  <= 1'b0;
      hist <= '0;
      held <= 1'b0;
      pre  <= '0;
    end else begin
      sy1 <= din;
      sy2 <= sy1;
      pre <= pre + 1'b1;
      if (tick) begin
        hist <= {hist[SAMPLES-3:0], sy2};
        if (all_hi)      held <= 1'b1;
        else if (all_lo) held <= 1'b0;
      end
    end
  end

  assign dout = flt_on ? held : sy2;

  // R9
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(held));
  // R9
  filt_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && all_hi) |=> held);
endmodule

// File: rtl/qec_cond.sv
module qec_cond (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lvl_a,
  input  logic                          lvl_b,
  input  logic                          lvl_t,
  input  logic                          evt,
  input  logic                          n_ovf,
  input  logic                          n_unf,
  input  logic [qec_pkg::NUM_COND-1:0]  inc_mask,
  input  logic [qec_pkg::NUM_COND-1:0]  dec_mask,
  output logic                          up,
  output logic                          dn
);
  import qec_pkg::*;

  logic a_q, b_q, t_q;
  logic a_r, a_f, b_r, b_f, t_r, t_f;
  logic [NUM_COND-1:0] cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      t_q <= 1'b0;
    end else begin
      a_q <= lvl_a;
      b_q <= lvl_b;
      t_q <= lvl_t;
    end
  end

  assign a_r = lvl_a & ~a_q;
  assign a_f = ~lvl_a & a_q;
  assign b_r = lvl_b & ~b_q;
  assign b_f = ~lvl_b & b_q;
  assign t_r = lvl_t & ~t_q;
  assign t_f = ~lvl_t & t_q;

  always_comb begin
    cond[0]  = b_r & ~a_q;
    cond[1]  = b_f & ~a_q;
    cond[2]  = b_r &  a_q;
    cond[3]  = b_f &  a_q;
    cond[4]  = a_r & ~b_q;
    cond[5]  = a_f & ~b_q;
    cond[6]  = a_r &  b_q;
    cond[7]  = a_f &  b_q;
    cond[8]  = t_r;
    cond[9]  = t_f;
    cond[10] = evt;
    cond[11] = n_ovf;
    cond[12] = n_unf;
  end

  assign up = |(cond & inc_mask);
  assign dn = |(cond & dec_mask);

  // R3
  b_edge_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond[3:0]));
  // R3
  a_edge_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond[7:4]));
endmodule

// File: rtl/qec_count.sv
module qec_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up,
  input  logic          dn,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic step_up, step_dn;
  assign step_up = up & ~dn;
  assign step_dn = dn & ~up;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic u, input logic d);
    if (u)      return c + 1'b1;
    else if (d) return c - 1'b1;
    else        return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else if (load_en) begin
      count <= load_val;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      count <= next_count(count, step_up, step_dn);
      ovf   <= step_up && (count == MAXV);
      unf   <= step_dn && (count == '0);
    end
  end

  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0 && $past(count) == MAXV));
  // R7
  unf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (count == MAXV && $past(count) == '0));
  // R7
  wrap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn && !load_en) |=> $stable(count));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (count == $past(load_val) && !ovf && !unf));
endmodule

// File: rtl/quad_event_counter.sv
module quad_event_counter #(
  parameter int CW      = 16,
  parameter int SAMPLES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enc_a,
  input  logic                          enc_b,
  input  logic                          trig_in,
  input  logic                          evt_in,
  input  logic                          nbr_ovf,
  input  logic                          nbr_unf,
  input  logic [qec_pkg::NUM_PIN-1:0]   flt_en,
  input  logic [1:0]                    flt_sel_a,
  input  logic [1:0]                    flt_sel_b,
  input  logic [1:0]                    flt_sel_t,
  input  logic [qec_pkg::NUM_COND-1:0]  inc_mask,
  input  logic [qec_pkg::NUM_COND-1:0]  dec_mask,
  input  logic                          load_en,
  input  logic [CW-1:0]                 load_val,
  output logic [CW-1:0]                 count,
  output logic                          ovf,
  output logic                          unf
);
  import qec_pkg::*;

  logic [NUM_PIN-1:0] pin_raw, pin_lvl;
  logic [1:0]         pin_sel [NUM_PIN];
  logic               step_up, step_dn;

  assign pin_raw[PIN_A] = enc_a;
  assign pin_raw[PIN_B] = enc_b;
  assign pin_raw[PIN_T] = trig_in;
  assign pin_sel[PIN_A] = flt_sel_a;
  assign pin_sel[PIN_B] = flt_sel_b;
  assign pin_sel[PIN_T] = flt_sel_t;

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_flt
    qec_filter #(.SAMPLES(SAMPLES)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (pin_raw[g]),
      .flt_on (flt_en[g]),
      .sel    (pin_sel[g]),
      .dout   (pin_lvl[g])
    );
  end

  qec_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_a    (pin_lvl[PIN_A]),
    .lvl_b    (pin_lvl[PIN_B]),
    .lvl_t    (pin_lvl[PIN_T]),
    .evt      (evt_in),
    .n_ovf    (nbr_ovf),
    .n_unf    (nbr_unf),
    .inc_mask (inc_mask),
    .dec_mask (dec_mask),
    .up       (step_up),
    .dn       (step_dn)
  );

  qec_count #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (step_up),
    .dn       (step_dn),
    .load_en  (load_en),
    .load_val (load_val),
    .count    (count),
    .ovf      (ovf),
    .unf      (unf)
  );
endmodule

// File: tb/sim_quad_event_counter.sv
`timescale 1ns/1ps
module sim_quad_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 0, enc_b = 0, trig_in = 0, evt_in = 0, nbr_ovf = 0, nbr_unf = 0;
  logic [2:0]  flt_en = 3'b000;
  logic [1:0]  flt_sel_a = 0, flt_sel_b = 0, flt_sel_t = 0;
  logic [12:0] inc_mask = 0, dec_mask = 0;
  logic        load_en = 0;
  logic [15:0] load_val = 0;
  logic [15:0] count;
  logic        ovf, unf;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  quad_event_counter u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .trig_in(trig_in),
    .evt_in(evt_in), .nbr_ovf(nbr_ovf), .nbr_unf(nbr_unf), .flt_en(flt_en),
    .flt_sel_a(flt_sel_a), .flt_sel_b(flt_sel_b), .flt_sel_t(flt_sel_t),
    .inc_mask(inc_mask), .dec_mask(dec_mask), .load_en(load_en),
    .load_val(load_val), .count(count), .ovf(ovf), .unf(unf)
  );

  // st/fin bits are {a,b,trig}; d: 0 none, 1 plus one, 2 minus one
  typedef struct packed {
    logic [12:0] im;
    logic [12:0] dm;
    logic [2:0]  st;
    logic [2:0]  fin;
    logic [1:0]  d;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{13'h001, 13'h000, 3'b000, 3'b010, 2'd1},
    '{13'h001, 13'h000, 3'b100, 3'b110, 2'd0},
    '{13'h004, 13'h000, 3'b100, 3'b110, 2'd1},
    '{13'h000, 13'h002, 3'b010, 3'b000, 2'd2},
    '{13'h000, 13'h008, 3'b110, 3'b100, 2'd2},
    '{13'h010, 13'h000, 3'b000, 3'b100, 2'd1},
    '{13'h020, 13'h000, 3'b100, 3'b000, 2'd1},
    '{13'h000, 13'h040, 3'b010, 3'b110, 2'd2},
    '{13'h000, 13'h080, 3'b110, 3'b010, 2'd2},
    '{13'h010, 13'h010, 3'b000, 3'b100, 2'd0},
    '{13'h0FF, 13'h000, 3'b000, 3'b100, 2'd1},
    '{13'h000, 13'h080, 3'b010, 3'b110, 2'd0},
    '{13'h100, 13'h000, 3'b000, 3'b001, 2'd1},
    '{13'h000, 13'h200, 3'b001, 3'b000, 2'd2},
    '{13'h100, 13'h000, 3'b001, 3'b000, 2'd0}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] v);
    load_en = 1'b1; load_val = v;
    cyc(1);
    load_en = 1'b0;
  endtask

  task automatic pulse_a(input int w, input int settle);
    enc_a = 1'b1; cyc(w);
    enc_a = 1'b0; cyc(settle);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1: state while held in reset
    chk("R1 count in reset", 32'(count), 32'h0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 ovf/unf", {30'b0, ovf, unf}, 32'h0);

    // table of encoder and trigger conditions
    for (int i = 0; i < NV; i++) begin
      int exp;
      string tag;
      do_load(16'h1000);
      {enc_a, enc_b, trig_in} = VEC[i].st;
      cyc(6);
      inc_mask = VEC[i].im; dec_mask = VEC[i].dm;
      {enc_a, enc_b, trig_in} = VEC[i].fin;
      cyc(6);
      exp = 32'h1000 + (VEC[i].d == 2'd1 ? 1 : (VEC[i].d == 2'd2 ? -1 : 0));
      if (i >= 12)                 tag = $sformatf("R4 vector %0d", i);
      else if (i == 9 || i == 10)  tag = $sformatf("R6 vector %0d", i);
      else                         tag = $sformatf("R3 vector %0d", i);
      chk(tag, 32'(count), 32'(exp[15:0]));
      inc_mask = 0; dec_mask = 0;
    end
    {enc_a, enc_b, trig_in} = 3'b000;
    cyc(6);

    // R3: exact latency, count changes at third rising edge
    do_load(16'h3000);
    inc_mask = 13'h010;
    enc_a = 1'b1;
    cyc(2);
    chk("R3 latency not yet", 32'(count), 32'h3000);
    cyc(1);
    chk("R3 latency due", 32'(count), 32'h3001);
    inc_mask = 0; enc_a = 1'b0; cyc(6);

    // R2: load wins over a simultaneous step
    inc_mask = 13'h400;
    load_en = 1'b1; load_val = 16'h5A5A; evt_in = 1'b1;
    cyc(1);
    load_en = 1'b0; evt_in = 1'b0;
    chk("R2 load priority", 32'(count), 32'h5A5A);
    chk("R2 no wrap flags", {30'b0, ovf, unf}, 32'h0);

    // R5 / R7: event step and up-wrap
    do_load(16'hFFFF);
    evt_in = 1'b1; cyc(1); evt_in = 1'b0;
    chk("R7 up-wrap count", 32'(count), 32'h0);
    chk("R7 ovf pulse", {31'b0, ovf}, 32'h1);
    cyc(1);
    chk("R7 ovf one cycle", {31'b0, ovf}, 32'h0);
    chk("R5 evt single step", 32'(count), 32'h0);

    // R7: down-wrap
    inc_mask = 0; dec_mask = 13'h400;
    evt_in = 1'b1; cyc(1); evt_in = 1'b0;
    chk("R7 down-wrap count", 32'(count), 32'hFFFF);
    chk("R7 unf pulse", {31'b0, unf}, 32'h1);
    cyc(1);
    chk("R7 unf one cycle", {31'b0, unf}, 32'h0);

    // R5: neighbour cascade inputs
    dec_mask = 0; inc_mask = 13'h800;
    do_load(16'h0100);
    nbr_ovf = 1'b1; cyc(1); nbr_ovf = 1'b0;
    chk("R5 nbr_ovf inc", 32'(count), 32'h0101);
    inc_mask = 0; dec_mask = 13'h1000;
    nbr_unf = 1'b1; cyc(2); nbr_unf = 1'b0;
    chk("R5 nbr_unf dec twice", 32'(count), 32'h00FF);

    // R6: cancel across sources, and merging of several increments
    inc_mask = 13'h800; dec_mask = 13'h400;
    evt_in = 1'b1; nbr_ovf = 1'b1; cyc(1); evt_in = 1'b0; nbr_ovf = 1'b0;
    chk("R6 cancel", 32'(count), 32'h00FF);
    inc_mask = 13'hC00; dec_mask = 0;
    evt_in = 1'b1; nbr_ovf = 1'b1; cyc(1); evt_in = 1'b0; nbr_ovf = 1'b0;
    chk("R6 merged increments", 32'(count), 32'h0100);

    // filter tests on A: both A edges with B low increment
    inc_mask = 13'h030; dec_mask = 0;
    do_load(16'h2000);
    pulse_a(2, 10);
    chk("R8 unfiltered short pulse", 32'(count), 32'h2002);

    flt_en = 3'b001; flt_sel_a = 2'd0; cyc(4);
    do_load(16'h2000);
    pulse_a(2, 10);
    chk("R9 glitch rejected", 32'(count), 32'h2000);
    pulse_a(8, 10);
    chk("R9 long pulse accepted", 32'(count), 32'h2002);

    do_load(16'h2000);
    pulse_a(6, 12);
    chk("R10 6-clock pulse at select 0", 32'(count), 32'h2002);

    flt_sel_a = 2'd1; cyc(20);
    do_load(16'h2000);
    pulse_a(6, 20);
    chk("R10 6-clock pulse at select 1", 32'(count), 32'h2000);
    pulse_a(40, 40);
    chk("R10 long pulse at select 1", 32'(count), 32'h2002);

    flt_sel_a = 2'd3; cyc(300);
    do_load(16'h2000);
    pulse_a(100, 300);
    chk("R10 100-clock pulse at select 3", 32'(count), 32'h2000);
    pulse_a(300, 300);
    chk("R10 long pulse at select 3", 32'(count), 32'h2002);

    finish_run();
  end
endmodule